// File: doc/BRIEF.md
# True-Colour Video DAC Host Register Interface

This block is the host-side register file of a true-colour video DAC. A byte-wide synchronous bus reaches it through a 4-bit register select. The select is built from two bus address bits and two extra select inputs. A few registers are reached directly: an index register, an indexed-data port and the four bytes of the cursor position. All other control registers sit behind the index and are reached through the indexed-data port.

The indirect space holds pixel-format and clocking controls, a general-purpose I/O pair, and three clock synthesizer parameter sets (pixel, memory and loop clock). Each set has an N, an M and a P byte. One shared PLL address register packs a separate 2-bit pointer for each set. A pointer advances only when its own data port is written, so software can stream N, M and P into one synthesizer without touching the other two. Decoded control fields, the cursor position, the pointers and all synthesizer parameters are driven out as plain outputs. The pixel path and the synthesizers themselves use these outputs.

Top module: `vdac_regfile`

## Requirements
- R1: The register select is {ext_sel[1], ext_sel[0], bus_addr[1:0]}. Select 0x0 writes and reads the index register. Select 0xA is the indexed-data port. Selects 0xC, 0xD, 0xE and 0xF are cursor X low, X high, Y low and Y high. Writes to any other select change nothing, and reads from them return 0xFF.
- R2: cur_x and cur_y are 12 bits wide. A low-byte write replaces bits 7:0 and keeps bits 11:8. A high-byte write replaces bits 11:8 with wdata[3:0] and keeps bits 7:0. A high-byte read returns {4'h0, bits 11:8}.
- R3: The PLL address register is at index 0x2C. Bits 1:0 are the pixel pointer, bits 3:2 the memory pointer and bits 5:4 the loop pointer. Bits 7:6 are stored as well. A write loads all eight bits, a read returns them, and they appear on pll_ptrs.
- R4: A write to index 0x2D (pixel), 0x2E (memory) or 0x2F (loop) stores the byte into N, M or P when that set's pointer is 0, 1 or 2. When the pointer is 3, nothing is stored. The set's pointer then advances by one, modulo 4, and every other bit of the PLL address register keeps its value.
- R5: A read of indices 0x2D, 0x2E or 0x2F returns the parameter that the set's pointer selects. With pointer 3, the pixel and memory ports return 0x40 (locked) and the loop port returns 0xFF. Reads never move any pointer.
- R6: Index 0x3F reads 0x26 and index 0x01 reads 0x00. A read of an index that maps to no register returns 0xFF. A write to such an index changes no register and no pointer.
- R7: After reset, the registers hold these values: index 0x0F = 0x06, 0x18 = 0x80, 0x19 = 0x98, 0x1A = 0x07, 0x39 = 0x18. Every other register, pointer, cursor coordinate, parameter and rdata is 0.
- R8: Bit 3 of index 0x1E drives pal_8bit, which selects 8-bit palette data when high and 6-bit data when low. The full byte reads back.
- R9: A read of index 0x2B forms the mask 0xE0 | gpio control bits 4:0 (index 0x2A). Bits where the mask is 0 take gpio_in, bits where it is 1 keep their stored value, and the merged byte is both returned and stored.
- R10: rdata is registered. It carries the result in the cycle after a cycle with rd_en high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| bus_addr | input | 2 | Low two bits of the register select |
| ext_sel | input | 2 | High two bits of the register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gpio_in | input | 8 | External general-purpose input levels |
| cur_x | output | 12 | Cursor X position |
| cur_y | output | 12 | Cursor Y position |
| pal_8bit | output | 1 | 8-bit palette data select |
| latch_ctl | output | 8 | Latch control byte |
| true_ctl | output | 8 | True-colour control byte |
| mux_ctl | output | 8 | Multiplex control byte |
| clk_sel | output | 8 | Clock select byte |
| mclk_ctl | output | 8 | Memory/loop clock control byte |
| gpio_ctl | output | 8 | General-purpose I/O control byte |
| gpio_dat | output | 8 | General-purpose I/O stored data |
| pll_ptrs | output | 8 | PLL address register contents |
| pix_nmp | output | 24 | Pixel clock {P, M, N} |
| mem_nmp | output | 24 | Memory clock {P, M, N} |
| loop_nmp | output | 24 | Loop clock {P, M, N} |

## Verification
The assertions assume that the bus never raises wr_en and rd_en in the same cycle, so that no read result has to be ordered against a write to the same register. The stimulus drives each access as a one-cycle strobe set up on the falling edge, with at least one idle cycle after it. Random and directed operations alike go through the same two tasks, so the bench never asserts both strobes together. The random mix is weighted toward the index register and the indexed-data port, so the three pointer sets wrap through value 3 many times.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
  localparam int unsigned DW = 8;

  localparam logic [3:0] SEL_INDEX = 4'h0;
  localparam logic [3:0] SEL_IDATA = 4'hA;
  localparam logic [3:0] SEL_CXLO  = 4'hC;
  localparam logic [3:0] SEL_CXHI  = 4'hD;
  localparam logic [3:0] SEL_CYLO  = 4'hE;
  localparam logic [3:0] SEL_CYHI  = 4'hF;

  localparam logic [7:0] IX_REV    = 8'h01;
  localparam logic [7:0] IX_LATCH  = 8'h0F;
  localparam logic [7:0] IX_TRUE   = 8'h18;
  localparam logic [7:0] IX_MUX    = 8'h19;
  localparam logic [7:0] IX_CLKSEL = 8'h1A;
  localparam logic [7:0] IX_MISC   = 8'h1E;
  localparam logic [7:0] IX_GPCTL  = 8'h2A;
  localparam logic [7:0] IX_GPDAT  = 8'h2B;
  localparam logic [7:0] IX_PLLADR = 8'h2C;
  localparam logic [7:0] IX_PIXD   = 8'h2D;
  localparam logic [7:0] IX_MCLK   = 8'h39;
  localparam logic [7:0] IX_ID     = 8'h3F;

  localparam logic [7:0] RST_LATCH  = 8'h06;
  localparam logic [7:0] RST_TRUE   = 8'h80;
  localparam logic [7:0] RST_MUX    = 8'h98;
  localparam logic [7:0] RST_CLKSEL = 8'h07;
  localparam logic [7:0] RST_MCLK   = 8'h18;

  localparam logic [7:0] VAL_ID     = 8'h26;
  localparam logic [7:0] VAL_REV    = 8'h00;
  localparam logic [7:0] VAL_LOCK   = 8'h40;
  localparam logic [7:0] VAL_NONE   = 8'hFF;
  localparam logic [7:0] GPIO_KEEP  = 8'hE0;

  localparam int unsigned NSLOT = 3;
  localparam int unsigned PTR_W = 2;
endpackage

// File: rtl/vdac_coord_reg.sv
module vdac_coord_reg #(
  parameter int unsigned W  = 12,
  parameter int unsigned LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [LW-1:0]   lo_data,
  input  logic [W-LW-1:0] hi_data,
  output logic [W-1:0]    coord
);
  logic [W-1:0] coord_q;
  logic [W-1:0] coord_nxt;
  logic         coord_en;

  always_comb begin
    coord_nxt = coord_q;
    coord_en  = wr_lo | wr_hi;
    if (wr_lo) coord_nxt[LW-1:0] = lo_data;
    if (wr_hi) coord_nxt[W-1:LW] = hi_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        coord_q <= '0;
    else if (coord_en) coord_q <= coord_nxt;
  end

  assign coord = coord_q;
endmodule

// File: rtl/vdac_pll_slot.sv
module vdac_pll_slot #(
  parameter int unsigned PW      = 8,
  parameter bit          LOCK_RD = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [1:0]    ptr_val,
  input  logic          data_wr,
  input  logic [PW-1:0] wdata,
  output logic [1:0]    ptr,
  output logic [3*PW-1:0] nmp,
  output logic [PW-1:0] rd_val
);
  localparam int unsigned NPAR = 3;

  logic [1:0]    ptr_q;
  logic [1:0]    ptr_nxt;
  logic          ptr_en;
  logic [PW-1:0] par_q [NPAR];

  always_comb begin
    ptr_nxt = ptr_q;
    ptr_en  = ptr_ld | data_wr;
    if (ptr_ld)       ptr_nxt = ptr_val;
    else if (data_wr) ptr_nxt = ptr_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nxt;
  end

  for (genvar k = 0; k < NPAR; k++) begin : g_par
    logic par_en;
    assign par_en = data_wr && (ptr_q == 2'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      par_q[k] <= '0;
      else if (par_en) par_q[k] <= wdata;
    end
    assign nmp[k*PW +: PW] = par_q[k];
  end

  logic [PW-1:0] empty_val;
  if (LOCK_RD) begin : g_lock
    assign empty_val = PW'(vdac_pkg::VAL_LOCK);
  end else begin : g_nolock
    assign empty_val = PW'(vdac_pkg::VAL_NONE);
  end

  always_comb begin
    if (ptr_q == 2'd3) rd_val = empty_val;
    else               rd_val = par_q[ptr_q];
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/vdac_regfile.sv
module vdac_regfile
  import vdac_pkg::*;
#(
  parameter int unsigned COORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        bus_addr,
  input  logic [1:0]        ext_sel,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     gpio_in,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y,
  output logic              pal_8bit,
  output logic [DW-1:0]     latch_ctl,
  output logic [DW-1:0]     true_ctl,
  output logic [DW-1:0]     mux_ctl,
  output logic [DW-1:0]     clk_sel,
  output logic [DW-1:0]     mclk_ctl,
  output logic [DW-1:0]     gpio_ctl,
  output logic [DW-1:0]     gpio_dat,
  output logic [DW-1:0]     pll_ptrs,
  output logic [3*DW-1:0]   pix_nmp,
  output logic [3*DW-1:0]   mem_nmp,
  output logic [3*DW-1:0]   loop_nmp
);
  localparam int unsigned HI_W  = COORD_W - DW;
  localparam int unsigned TOP_W = DW - NSLOT*PTR_W;

  logic [3:0] sel;
  assign sel = {ext_sel, bus_addr};

  logic port_wr, port_rd;
  assign port_wr = wr_en && (sel == SEL_IDATA);
  assign port_rd = rd_en && (sel == SEL_IDATA);

  // ---------------- state ----------------
  logic [DW-1:0]    idx_q, latch_q, true_q, mux_q, clks_q, misc_q, gpc_q, gpd_q, mclk_q;
  logic [TOP_W-1:0] padr_top_q;
  logic [DW-1:0]    rdata_q;

  logic we_idx, we_latch, we_true, we_mux, we_clks, we_misc, we_gpc, we_gpd, we_mclk, we_padr;
  logic rd_gpd;
  logic [DW-1:0] gp_mask, gp_merged, gpd_nxt;
  logic gpd_en;

  always_comb begin
    we_idx   = wr_en && (sel == SEL_INDEX);
    we_latch = port_wr && (idx_q == IX_LATCH);
    we_true  = port_wr && (idx_q == IX_TRUE);
    we_mux   = port_wr && (idx_q == IX_MUX);
    we_clks  = port_wr && (idx_q == IX_CLKSEL);
    we_misc  = port_wr && (idx_q == IX_MISC);
    we_gpc   = port_wr && (idx_q == IX_GPCTL);
    we_gpd   = port_wr && (idx_q == IX_GPDAT);
    we_mclk  = port_wr && (idx_q == IX_MCLK);
    we_padr  = port_wr && (idx_q == IX_PLLADR);
    rd_gpd   = port_rd && (idx_q == IX_GPDAT);
  end

  always_comb begin
    gp_mask   = GPIO_KEEP | {3'b000, gpc_q[4:0]};
    gp_merged = (gpd_q & gp_mask) | (gpio_in & ~gp_mask);
    gpd_en    = we_gpd | rd_gpd;
    gpd_nxt   = we_gpd ? wdata : gp_merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      latch_q    <= RST_LATCH;
      true_q     <= RST_TRUE;
      mux_q      <= RST_MUX;
      clks_q     <= RST_CLKSEL;
      misc_q     <= '0;
      gpc_q      <= '0;
      gpd_q      <= '0;
      mclk_q     <= RST_MCLK;
      padr_top_q <= '0;
    end else begin
      if (we_idx)   idx_q      <= wdata;
      if (we_latch) latch_q    <= wdata;
      if (we_true)  true_q     <= wdata;
      if (we_mux)   mux_q      <= wdata;
      if (we_clks)  clks_q     <= wdata;
      if (we_misc)  misc_q     <= wdata;
      if (we_gpc)   gpc_q      <= wdata;
      if (gpd_en)   gpd_q      <= gpd_nxt;
      if (we_mclk)  mclk_q     <= wdata;
      if (we_padr)  padr_top_q <= wdata[DW-1:NSLOT*PTR_W];
    end
  end

  // ---------------- cursor position ----------------
  logic [COORD_W-1:0] coord_w [2];
  for (genvar a = 0; a < 2; a++) begin : g_coord
    logic wlo, whi;
    assign wlo = wr_en && (sel == (SEL_CXLO + 4'(2*a)));
    assign whi = wr_en && (sel == (SEL_CXHI + 4'(2*a)));
    vdac_coord_reg #(.W(COORD_W), .LW(DW)) u_coord (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wlo),
      .wr_hi   (whi),
      .lo_data (wdata),
      .hi_data (wdata[HI_W-1:0]),
      .coord   (coord_w[a])
    );
  end
  assign cur_x = coord_w[0];
  assign cur_y = coord_w[1];

  // ---------------- clock synthesizer sets ----------------
  logic [PTR_W-1:0] ptr_w [NSLOT];
  logic [3*DW-1:0]  nmp_w [NSLOT];
  logic [DW-1:0]    prd_w [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic dwr;
    assign dwr = port_wr && (idx_q == 8'(IX_PIXD + 8'(s)));
    vdac_pll_slot #(.PW(DW), .LOCK_RD(s < 2)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_ld  (we_padr),
      .ptr_val (wdata[s*PTR_W +: PTR_W]),
      .data_wr (dwr),
      .wdata   (wdata),
      .ptr     (ptr_w[s]),
      .nmp     (nmp_w[s]),
      .rd_val  (prd_w[s])
    );
  end

  logic [DW-1:0] padr_full;
  assign padr_full = {padr_top_q, ptr_w[2], ptr_w[1], ptr_w[0]};

  // ---------------- read path ----------------
  logic [DW-1:0] ind_val, rd_nxt;

  always_comb begin
    case (idx_q)
      IX_REV:           ind_val = VAL_REV;
      IX_LATCH:         ind_val = latch_q;
      IX_TRUE:          ind_val = true_q;
      IX_MUX:           ind_val = mux_q;
      IX_CLKSEL:        ind_val = clks_q;
      IX_MISC:          ind_val = misc_q;
      IX_GPCTL:         ind_val = gpc_q;
      IX_GPDAT:         ind_val = gp_merged;
      IX_PLLADR:        ind_val = padr_full;
      IX_PIXD:          ind_val = prd_w[0];
      IX_PIXD + 8'd1:   ind_val = prd_w[1];
      IX_PIXD + 8'd2:   ind_val = prd_w[2];
      IX_MCLK:          ind_val = mclk_q;
      IX_ID:            ind_val = VAL_ID;
      default:          ind_val = VAL_NONE;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_INDEX: rd_nxt = idx_q;
      SEL_IDATA: rd_nxt = ind_val;
      SEL_CXLO:  rd_nxt = coord_w[0][DW-1:0];
      SEL_CXHI:  rd_nxt = DW'(coord_w[0][COORD_W-1:DW]);
      SEL_CYLO:  rd_nxt = coord_w[1][DW-1:0];
      SEL_CYHI:  rd_nxt = DW'(coord_w[1][COORD_W-1:DW]);
      default:   rd_nxt = VAL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end

  // ---------------- outputs ----------------
  assign rdata     = rdata_q;
  assign pal_8bit  = misc_q[3];
  assign latch_ctl = latch_q;
  assign true_ctl  = true_q;
  assign mux_ctl   = mux_q;
  assign clk_sel   = clks_q;
  assign mclk_ctl  = mclk_q;
  assign gpio_ctl  = gpc_q;
  assign gpio_dat  = gpd_q;
  assign pll_ptrs  = padr_full;
  assign pix_nmp   = nmp_w[0];
  assign mem_nmp   = nmp_w[1];
  assign loop_nmp  = nmp_w[2];
endmodule

// File: rtl/vdac_regfile_chk.sv
module vdac_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  sel,
  input logic [7:0]  idx,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic [11:0] cur_x,
  input logic [7:0]  pll_ptrs,
  input logic        pal_8bit
);
  logic port_wr, port_rd;
  assign port_wr = wr_en && (sel == 4'hA);
  assign port_rd = rd_en && (sel == 4'hA);

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R1

  AST_CURX_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 4'hC) |=> (cur_x[7:0] == $past(wdata)) && (cur_x[11:8] == $past(cur_x[11:8]))); // R2

  AST_PIX_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && idx == 8'h2D) |=> (pll_ptrs[1:0] == 2'($past(pll_ptrs[1:0]) + 2'd1)) && (pll_ptrs[7:2] == $past(pll_ptrs[7:2]))); // R4

  AST_LOOP_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && idx == 8'h2F) |=> (pll_ptrs[5:4] == 2'($past(pll_ptrs[5:4]) + 2'd1)) && (pll_ptrs[3:0] == $past(pll_ptrs[3:0]))); // R4

  AST_READ_KEEPS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> $stable(pll_ptrs)); // R5

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rd && idx == 8'h3F) |=> (rdata == 8'h26)); // R6

  AST_PAL_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && idx == 8'h1E) |=> (pal_8bit == $past(wdata[3]))); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10
endmodule

bind vdac_regfile vdac_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .sel      ({ext_sel, bus_addr}),
  .idx      (idx_q),
  .wdata    (wdata),
  .rdata    (rdata),
  .cur_x    (cur_x),
  .pll_ptrs (pll_ptrs),
  .pal_8bit (pal_8bit)
);

// File: tb/vdac_regfile_tb.sv
module vdac_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [1:0]  ext_sel = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  gpio_in = '0;
  logic [7:0]  rdata;
  logic [11:0] cur_x, cur_y;
  logic        pal_8bit;
  logic [7:0]  latch_ctl, true_ctl, mux_ctl, clk_sel, mclk_ctl, gpio_ctl, gpio_dat, pll_ptrs;
  logic [23:0] pix_nmp, mem_nmp, loop_nmp;

  always #5 clk = ~clk;

  vdac_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .bus_addr(bus_addr), .ext_sel(ext_sel), .wdata(wdata), .rdata(rdata),
    .gpio_in(gpio_in), .cur_x(cur_x), .cur_y(cur_y), .pal_8bit(pal_8bit),
    .latch_ctl(latch_ctl), .true_ctl(true_ctl), .mux_ctl(mux_ctl),
    .clk_sel(clk_sel), .mclk_ctl(mclk_ctl), .gpio_ctl(gpio_ctl),
    .gpio_dat(gpio_dat), .pll_ptrs(pll_ptrs), .pix_nmp(pix_nmp),
    .mem_nmp(mem_nmp), .loop_nmp(loop_nmp)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // ---------------- requirement model ----------------
  logic [7:0]  m_reg [256];
  logic [7:0]  m_idx;
  logic [11:0] m_cx, m_cy;
  logic [1:0]  m_ptr [3];
  logic [1:0]  m_top;
  logic [7:0]  m_par [9];

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
    m_reg[8'h0F] = 8'h06; m_reg[8'h18] = 8'h80; m_reg[8'h19] = 8'h98;
    m_reg[8'h1A] = 8'h07; m_reg[8'h39] = 8'h18;
    m_idx = 0; m_cx = 0; m_cy = 0; m_top = 0;
    for (int i = 0; i < 3; i++) m_ptr[i] = 0;
    for (int i = 0; i < 9; i++) m_par[i] = 0;
  endtask

  function automatic bit is_plain(logic [7:0] ix);
    return ix inside {8'h0F, 8'h18, 8'h19, 8'h1A, 8'h1E, 8'h2A, 8'h2B, 8'h39};
  endfunction

  function automatic logic [7:0] ind_expect(logic [7:0] ix);
    int s;
    if (ix == 8'h01) return 8'h00;
    if (ix == 8'h3F) return 8'h26;
    if (ix == 8'h2C) return {m_top, m_ptr[2], m_ptr[1], m_ptr[0]};
    if (ix >= 8'h2D && ix <= 8'h2F) begin
      s = int'(ix - 8'h2D);
      if (m_ptr[s] == 2'd3) return (s < 2) ? 8'h40 : 8'hFF;
      return m_par[s*3 + int'(m_ptr[s])];
    end
    if (is_plain(ix)) return m_reg[ix];
    return 8'hFF;
  endfunction

  function automatic string tag_of(logic [3:0] s, logic [7:0] ix);
    if (s >= 4'hC) return "R2";
    if (s != 4'hA) return "R1";
    if (ix == 8'h2C) return "R3";
    if (ix >= 8'h2D && ix <= 8'h2F) return "R5";
    if (ix == 8'h2B) return "R9";
    if (ix == 8'h1E) return "R8";
    if (is_plain(ix)) return "R7";
    return "R6";
  endfunction

  task automatic model_wr(logic [3:0] s, logic [7:0] d);
    int k;
    case (s)
      4'h0: m_idx = d;
      4'hA: begin
        if (is_plain(m_idx)) m_reg[m_idx] = d;
        else if (m_idx == 8'h2C) begin
          m_ptr[0] = d[1:0]; m_ptr[1] = d[3:2]; m_ptr[2] = d[5:4]; m_top = d[7:6];
        end else if (m_idx >= 8'h2D && m_idx <= 8'h2F) begin
          k = int'(m_idx - 8'h2D);
          if (m_ptr[k] != 2'd3) m_par[k*3 + int'(m_ptr[k])] = d;
          m_ptr[k] = m_ptr[k] + 2'd1;
        end
      end
      4'hC: m_cx[7:0]  = d;
      4'hD: m_cx[11:8] = d[3:0];
      4'hE: m_cy[7:0]  = d;
      4'hF: m_cy[11:8] = d[3:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] model_rd(logic [3:0] s, logic [7:0] gin);
    logic [7:0] mask;
    case (s)
      4'h0: return m_idx;
      4'hA: begin
        if (m_idx == 8'h2B) begin
          mask = 8'hE0 | {3'b000, m_reg[8'h2A][4:0]};
          m_reg[8'h2B] = (m_reg[8'h2B] & mask) | (gin & ~mask);
          return m_reg[8'h2B];
        end
        return ind_expect(m_idx);
      end
      4'hC: return m_cx[7:0];
      4'hD: return {4'h0, m_cx[11:8]};
      4'hE: return m_cy[7:0];
      4'hF: return {4'h0, m_cy[11:8]};
      default: return 8'hFF;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic outputs_chk();
    chk("R2 cur_x", 32'(cur_x), 32'(m_cx));
    chk("R2 cur_y", 32'(cur_y), 32'(m_cy));
    chk("R3 pll_ptrs", 32'(pll_ptrs), 32'({m_top, m_ptr[2], m_ptr[1], m_ptr[0]}));
    chk("R4 pix_nmp", 32'(pix_nmp), 32'({m_par[2], m_par[1], m_par[0]}));
    chk("R4 mem_nmp", 32'(mem_nmp), 32'({m_par[5], m_par[4], m_par[3]}));
    chk("R4 loop_nmp", 32'(loop_nmp), 32'({m_par[8], m_par[7], m_par[6]}));
    chk("R8 pal_8bit", 32'(pal_8bit), 32'(m_reg[8'h1E][3]));
    chk("R7 true_ctl", 32'(true_ctl), 32'(m_reg[8'h18]));
    chk("R9 gpio_dat", 32'(gpio_dat), 32'(m_reg[8'h2B]));
  endtask

  task automatic do_wr(logic [3:0] s, logic [7:0] d);
    @(negedge clk);
    {ext_sel, bus_addr} = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(s, d);
  endtask

  task automatic do_rd(logic [3:0] s, logic [7:0] gin);
    logic [7:0] exp;
    string tg;
    tg = tag_of(s, m_idx);
    @(negedge clk);
    {ext_sel, bus_addr} = s; gpio_in = gin; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    exp = model_rd(s, gin);
    chk({tg, " read"}, 32'(rdata), 32'(exp));
  endtask

  task automatic rd_idx(logic [7:0] ix);
    do_wr(4'h0, ix);
    do_rd(4'hA, 8'h00);
  endtask

  logic [7:0] idx_pool [16] = '{8'h01, 8'h0F, 8'h18, 8'h19, 8'h1A, 8'h1E, 8'h2A, 8'h2B,
                                8'h2C, 8'h2D, 8'h2E, 8'h2F, 8'h39, 8'h3F, 8'h05, 8'h40};

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h00C0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state at the ports and through reads
    chk("R7 rdata reset", 32'(rdata), 32'h0);
    chk("R7 latch_ctl", 32'(latch_ctl), 32'h06);
    chk("R7 mux_ctl", 32'(mux_ctl), 32'h98);
    chk("R7 clk_sel", 32'(clk_sel), 32'h07);
    chk("R7 mclk_ctl", 32'(mclk_ctl), 32'h18);
    outputs_chk();
    foreach (idx_pool[i]) rd_idx(idx_pool[i]);

    // R6 id, revision, unmapped index write ignored
    rd_idx(8'h3F); rd_idx(8'h01);
    do_wr(4'h0, 8'h55); do_wr(4'hA, 8'hA5);
    rd_idx(8'h55); outputs_chk();
    foreach (idx_pool[i]) if (is_plain(idx_pool[i])) rd_idx(idx_pool[i]);

    // R1 unmapped selects: writes ignored, reads 0xFF
    for (int s = 1; s < 12; s++) if (s != 10) begin
      do_wr(4'(s), 8'h3C); do_rd(4'(s), 8'h00);
    end
    do_rd(4'h0, 8'h00); outputs_chk();

    // R2 cursor halves
    do_wr(4'hC, 8'hAB); do_wr(4'hD, 8'hF7); do_wr(4'hE, 8'h12); do_wr(4'hF, 8'h3E);
    outputs_chk();
    do_wr(4'hC, 8'h01); outputs_chk();
    for (int s = 12; s < 16; s++) do_rd(4'(s), 8'h00);

    // R3 R4 R5 pointer sequencing incl. pointer 3 and wrap
    do_wr(4'h0, 8'h2C); do_wr(4'hA, 8'hC0);
    do_wr(4'h0, 8'h2D);
    do_wr(4'hA, 8'h11); do_wr(4'hA, 8'h22); do_wr(4'hA, 8'h33); do_wr(4'hA, 8'h44);
    outputs_chk();
    do_wr(4'h0, 8'h2E); do_wr(4'hA, 8'h5A); outputs_chk();
    rd_idx(8'h2C); rd_idx(8'h2D); rd_idx(8'h2D); rd_idx(8'h2E);
    do_wr(4'h0, 8'h2C); do_wr(4'hA, 8'h3F);
    rd_idx(8'h2D); rd_idx(8'h2D); rd_idx(8'h2E); rd_idx(8'h2F); rd_idx(8'h2C);
    outputs_chk();

    // R8 palette width select
    do_wr(4'h0, 8'h1E); do_wr(4'hA, 8'h08); outputs_chk();
    do_wr(4'hA, 8'hF7); outputs_chk(); do_rd(4'hA, 8'h00);

    // R9 gpio merge
    do_wr(4'h0, 8'h2A); do_wr(4'hA, 8'h05);
    do_wr(4'h0, 8'h2B); do_wr(4'hA, 8'hFF);
    do_rd(4'hA, 8'h00); outputs_chk();
    do_rd(4'hA, 8'h5A); outputs_chk();

    // R10 read data holds across idle cycles and writes
    rd_idx(8'h19);
    held = rdata;
    repeat (3) @(negedge clk);
    do_wr(4'hC, 8'h77);
    chk("R10 rdata hold", 32'(rdata), 32'(held));

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s;
      logic [7:0] d;
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3)      s = 4'h0;
      else if (r < 7) s = 4'hA;
      else            s = 4'($urandom_range(0, 15));
      if (s == 4'h0) d = idx_pool[$urandom_range(0, 15)];
      else           d = 8'($urandom);
      if ($urandom_range(0, 1) == 0) do_wr(s, d);
      else                           do_rd(s, 8'($urandom));
      if (n % 50 == 0) outputs_chk();
    end
    outputs_chk();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule